// File: doc/BRIEF.md
# Strap-Configured Emulation Chip-Select Decoder

This block lets external emulation hardware stand in for on-chip port registers and on-chip read-only memory. When reset is released it samples a few strap pins from the data bus and the bus-error line, and holds the resulting emulation configuration until the next reset. After that it watches each bus cycle, marked by an active-low address strobe, and compares the address against a parameter list of externally mapped port registers and against a parameter memory window.

When an access hits an external target in an enabled mode, the block drives one of two active-low chip selects for a fixed number of clocks. It also drops the internal-respond enable, so the on-chip logic stays silent and the external device answers instead. A memory-window access ends with a one-cycle termination pulse produced inside the block, which keeps the cycle length fixed. Any address that matches nothing leaves both chip selects high and keeps the internal response enabled.

Top module: `emu_cs_decoder`

## Requirements
- R1: Port emulation is latched when, at reset release, strap_dat10 is 0, strap_berr is 1 and strap_dat1 is 0. Any other combination leaves every emulation mode off.
- R2: Memory emulation is latched only when the port-emulation conditions hold and strap_dat13 is also 0. With strap_dat13 at 1, port emulation alone is active.
- R3: While rst_n is low, both chip selects are 1 and int_resp_en is 1. Straps are captured once, on the first rising clock edge with rst_n high, and strap changes after that have no effect.
- R4: In port emulation, a falling address strobe on any of the eleven external register addresses (defaults 0xFFFA00 + 2*i, for i = 0 to 10) drives cs_port_n low from the next rising clock edge onward.
- R5: Port registers kept internal (defaults 0xFFFA16, 0xFFFA18, 0xFFFA1A, 0xFFFA1C), and any other unlisted address, produce no chip select and leave int_resp_en at 1.
- R6: int_resp_en is 0, without waiting for a clock, whenever as_n is 0 and the address hits an external target of an enabled mode.
- R7: With as_n held low, cs_port_n stays low for exactly PORT_CYCLES clocks (default 3).
- R8: In memory emulation, an access to an address from MEM_LO to MEM_HI, both ends included (defaults 0x040000 and 0x07FFFF), drives cs_mem_n low. The addresses just outside the window stay internal.
- R9: cs_mem_n stays low for exactly MEM_CYCLES clocks (default 3). In the cycle after it expires, cyc_term is 1 for one clock.
- R10: If as_n rises before the count expires, the active chip select goes high on the next rising edge and cyc_term stays 0.
- R11: When port emulation is off, the port register addresses stay internal. When memory emulation is off, the memory window stays internal.
- R12: cs_port_n and cs_mem_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_dat1 | input | 1 | Data bit 1, sampled at reset release |
| strap_dat10 | input | 1 | Data bit 10, sampled at reset release |
| strap_dat13 | input | 1 | Data bit 13, sampled at reset release |
| strap_berr | input | 1 | Bus-error line, sampled at reset release |
| addr | input | AW | Bus address |
| as_n | input | 1 | Active-low address strobe |
| cs_port_n | output | 1 | Active-low chip select for port emulation |
| cs_mem_n | output | 1 | Active-low chip select for memory emulation |
| int_resp_en | output | 1 | High when the on-chip logic may answer the access |
| cyc_term | output | 1 | One-cycle pulse that ends a memory-emulation cycle |

## Verification
The assertions assume that the address stays stable while the strobe is low and that the strobe goes high for at least one clock between cycles, so that every falling edge is seen. The bench meets both assumptions. Each access task sets the address and lowers the strobe together on a falling clock edge, and raises the strobe before the next task begins. Straps are driven only while reset is asserted. They are inverted immediately after capture, which checks that they are ignored from then on.

// File: rtl/emu_cs_decoder.sv
module emu_cs_decoder #(
  parameter int AW = 24,
  parameter int EXT_REG_CNT = 11,
  parameter logic [EXT_REG_CNT*AW-1:0] EXT_REG_ADDRS = {
    24'hFFFA14, 24'hFFFA12, 24'hFFFA10, 24'hFFFA0E, 24'hFFFA0C, 24'hFFFA0A,
    24'hFFFA08, 24'hFFFA06, 24'hFFFA04, 24'hFFFA02, 24'hFFFA00},
  parameter logic [AW-1:0] MEM_LO = 24'h040000,
  parameter logic [AW-1:0] MEM_HI = 24'h07FFFF,
  parameter int PORT_CYCLES = 3,
  parameter int MEM_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_dat1,
  input  logic          strap_dat10,
  input  logic          strap_dat13,
  input  logic          strap_berr,
  input  logic [AW-1:0] addr,
  input  logic          as_n,
  output logic          cs_port_n,
  output logic          cs_mem_n,
  output logic          int_resp_en,
  output logic          cyc_term
);

  localparam int MAXC = (PORT_CYCLES > MEM_CYCLES) ? PORT_CYCLES : MEM_CYCLES;
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic          latched, port_mode, mem_mode;
  logic          as_q, cs_port_q, cs_mem_q, term_q;
  logic [CW-1:0] cnt;
  logic [EXT_REG_CNT-1:0] reg_match;

  for (genvar g = 0; g < EXT_REG_CNT; g++) begin : g_match
    assign reg_match[g] = (addr == EXT_REG_ADDRS[g*AW +: AW]);
  end

  wire strap_ok = !strap_dat10 && strap_berr && !strap_dat1;
  wire port_hit = port_mode && (|reg_match);
  wire mem_hit  = mem_mode && (addr >= MEM_LO) && (addr <= MEM_HI);
  wire active   = !cs_port_q || !cs_mem_q;

  assign int_resp_en = as_n || !(port_hit || mem_hit);
  assign cs_port_n   = cs_port_q;
  assign cs_mem_n    = cs_mem_q;
  assign cyc_term    = term_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched   <= 1'b0;
      port_mode <= 1'b0;
      mem_mode  <= 1'b0;
    end else if (!latched) begin
      latched   <= 1'b1;
      port_mode <= strap_ok;
      mem_mode  <= strap_ok && !strap_dat13;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q      <= 1'b1;
      cs_port_q <= 1'b1;
      cs_mem_q  <= 1'b1;
      term_q    <= 1'b0;
      cnt       <= '0;
    end else begin
      as_q   <= as_n;
      term_q <= 1'b0;
      if (active) begin
        if (as_n) begin
          cs_port_q <= 1'b1;
          cs_mem_q  <= 1'b1;
        end else if (cnt == '0) begin
          term_q    <= !cs_mem_q;
          cs_port_q <= 1'b1;
          cs_mem_q  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (!as_n && as_q) begin
        if (port_hit) begin
          cs_port_q <= 1'b0;
          cnt       <= CW'(PORT_CYCLES - 1);
        end else if (mem_hit) begin
          cs_mem_q <= 1'b0;
          cnt      <= CW'(MEM_CYCLES - 1);
        end
      end
    end
  end

  int low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= 0;
    else if (!cs_port_n || !cs_mem_n) low_run <= low_run + 1;
    else low_run <= 0;
  end

  // R12
  cs_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs_port_n && !cs_mem_n));

  // R2
  mem_needs_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_mode |-> port_mode);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(latched) |-> ($stable(port_mode) && $stable(mem_mode)));

  // R11
  port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_mode |-> cs_port_n);

  // R11
  mem_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_mode |-> cs_mem_n);

  // R10
  strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (as_n && $past(as_n)) |-> (cs_port_n && cs_mem_n));

  // R9
  term_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_term |-> ($past(!cs_mem_n) && cs_mem_n));

  // R7
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= MAXC);

  // R6
  resp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_port_n || !cs_mem_n) && !as_n |-> !int_resp_en);

endmodule

// File: tb/emu_cs_decoder_tb_top.sv
module emu_cs_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d1 = 1'b1, d10 = 1'b1, d13 = 1'b1, berr = 1'b0;
  logic [23:0] addr = '0;
  logic as_n = 1'b1;
  logic cs_port_n, cs_mem_n, int_resp_en, cyc_term;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  emu_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .strap_dat1(d1), .strap_dat10(d10),
    .strap_dat13(d13), .strap_berr(berr), .addr(addr), .as_n(as_n),
    .cs_port_n(cs_port_n), .cs_mem_n(cs_mem_n),
    .int_resp_en(int_resp_en), .cyc_term(cyc_term));

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // R3: straps driven during reset, captured at release, then inverted
  task automatic do_reset(input logic s1, input logic s10, input logic s13, input logic sb);
    @(negedge clk);
    rst_n = 1'b0; d1 = s1; d10 = s10; d13 = s13; berr = sb;
    as_n = 1'b0; addr = 24'hFFFA00;
    @(negedge clk); #1;
    chk(cs_port_n, 1'b1, "R3 cs_port_n in reset");
    chk(cs_mem_n, 1'b1, "R3 cs_mem_n in reset");
    chk(int_resp_en, 1'b1, "R3 int_resp_en in reset");
    as_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    d1 = ~s1; d10 = ~s10; d13 = ~s13; berr = ~sb;
    @(negedge clk);
  endtask

  // kind: 0 internal, 1 port chip select, 2 memory chip select
  task automatic access(input logic [23:0] a, input int kind, input bit early, input string tag);
    @(negedge clk);
    addr = a; as_n = 1'b0;
    #1 chk(int_resp_en, kind == 0, {tag, " R6 int_resp_en"});
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk); #1;
      chk(cs_port_n, kind != 1, $sformatf("%s R4 R7 cs_port_n cycle %0d", tag, c));
      chk(cs_mem_n, kind != 2, $sformatf("%s R8 R9 cs_mem_n cycle %0d", tag, c));
      chk(cs_port_n | cs_mem_n, 1'b1, {tag, " R12 exclusive"});
      if (early) begin
        as_n = 1'b1;
        @(negedge clk); #1;
        chk(cs_port_n & cs_mem_n, 1'b1, {tag, " R10 early deassert"});
        chk(cyc_term, 1'b0, {tag, " R10 no term"});
        return;
      end
    end
    @(negedge clk); #1;
    chk(cs_port_n & cs_mem_n, 1'b1, {tag, " R7 R9 expiry"});
    chk(cyc_term, kind == 2, {tag, " R9 term pulse"});
    @(negedge clk); #1;
    chk(cyc_term, 1'b0, {tag, " R9 term one cycle"});
    as_n = 1'b1;
  endtask

  task automatic port_only_test();
    do_reset(1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 11; i++) access(24'hFFFA00 + 24'(2*i), 1, 1'b0, "R1 R4 port reg");
    access(24'hFFFA16, 0, 1'b0, "R5 port C data");
    access(24'hFFFA18, 0, 1'b0, "R5 port F data");
    access(24'hFFFA1A, 0, 1'b0, "R5 port F dir");
    access(24'hFFFA1C, 0, 1'b0, "R5 port F pin");
    access(24'h123456, 0, 1'b0, "R5 unlisted");
    access(24'h040000, 0, 1'b0, "R2 R3 R11 mem off");
  endtask

  task automatic full_test();
    do_reset(1'b0, 1'b0, 1'b0, 1'b1);
    access(24'h040000, 2, 1'b0, "R8 low bound");
    access(24'h07FFFF, 2, 1'b0, "R8 high bound");
    access(24'h03FFFF, 0, 1'b0, "R8 below");
    access(24'h080000, 0, 1'b0, "R8 above");
    access(24'h055000, 2, 1'b1, "R10 mem early");
    access(24'hFFFA0C, 1, 1'b1, "R10 port early");
    access(24'hFFFA04, 1, 1'b0, "R2 port still on");
  endtask

  task automatic off_test();
    do_reset(1'b0, 1'b1, 1'b0, 1'b1);
    access(24'hFFFA00, 0, 1'b0, "R1 R11 dat10 high");
    access(24'h040000, 0, 1'b0, "R1 R11 mem dat10 high");
    do_reset(1'b0, 1'b0, 1'b0, 1'b0);
    access(24'hFFFA02, 0, 1'b0, "R1 berr low");
    do_reset(1'b1, 1'b0, 1'b0, 1'b1);
    access(24'hFFFA02, 0, 1'b0, "R1 dat1 high");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    port_only_test();
    full_test();
    off_test();
    summary();
    $finish;
  end
endmodule